// File: doc/BRIEF.md
# Writeback Slot Reservation Shift Register

This block gives a single-write-port register file a conflict-free schedule for results from fixed-latency functional units. The conflict is settled when the instruction issues, not when its result completes. At issue, the instruction presents its unit latency and its destination register. The block looks at the future writeback cycle that the latency points to. If that cycle is still free, the block books it and accepts the issue. If the cycle is already booked, the block raises a stall, and the issue stage holds the instruction for that cycle.

The bookings live in a line of slots that moves one position toward the head on every clock. The slot at the head drives the register-file write enable and the write address in the cycle the result is due. Since the check is made at issue, two results can never be due in the same cycle, and no arbiter is needed at completion. Only units with a fixed, known latency can use this scheme.

Top module: `wb_slot_reserve`

## Requirements
- R1: While `rst` is high at a clock edge, every booking is cleared, and after reset `wb_en` stays low until an issue is accepted.
- R2: An issue with latency L (1 ≤ L ≤ DEPTH) whose slot is free raises `iss_accept` in its own cycle. Exactly L cycles later, `wb_en` is high for one cycle with `wb_tag` equal to the issued `iss_dst`.
- R3: An issue with a legal latency L whose target cycle is already booked raises `iss_stall`. It does not raise `iss_accept` and makes no booking. The earlier booking still writes back with its own tag in its own cycle.
- R4: A latency of 0, or a latency greater than DEPTH, raises `lat_err` in the same cycle. It raises neither `iss_accept` nor `iss_stall`, and no write results from it.
- R5: An issue with latency equal to DEPTH never stalls. An issue of latency DEPTH in every cycle is accepted in every cycle and writes back in every cycle.
- R6: With `iss_req` low, `iss_accept`, `iss_stall` and `lat_err` are all low.
- R7: `wb_en` is never high for more than one result in a cycle. Every accepted instruction produces exactly one write.
- R8: `iss_accept` and `iss_stall` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| iss_req | input | 1 | An instruction asks to issue this cycle |
| iss_lat | input | LAT_W | Latency of the instruction's unit, in cycles |
| iss_dst | input | TAG_W | Destination register of the instruction |
| iss_accept | output | 1 | Slot booked, instruction issues |
| iss_stall | output | 1 | Target slot taken, hold the instruction |
| lat_err | output | 1 | Requested latency outside 1..DEPTH |
| wb_en | output | 1 | Register-file write enable for this cycle |
| wb_tag | output | TAG_W | Register-file write address for this cycle |

## Verification
The embedded assertions check the issue verdicts on every cycle: accept and stall never occur together, an illegal latency never books a slot, and an idle request produces no verdict. They also check that each booking lands at index L-1, and that the line moves by one position whenever nothing is inserted. Only the bench's scenarios can show end-to-end timing: that a write appears exactly L cycles after an accepted issue, with the right tag. The scenarios also cover a stalled issue leaving the earlier booking intact, and back-to-back issues at the full depth being sustained, none of which a single-cycle property can capture.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

    typedef enum logic [1:0] {
        VERDICT_IDLE    = 2'd0,
        VERDICT_ACCEPT  = 2'd1,
        VERDICT_STALL   = 2'd2,
        VERDICT_ILLEGAL = 2'd3
    } verdict_e;

    function automatic verdict_e decide(input logic req, input logic legal, input logic busy);
        if (!req)
            return VERDICT_IDLE;
        else if (!legal)
            return VERDICT_ILLEGAL;
        else if (busy)
            return VERDICT_STALL;
        else
            return VERDICT_ACCEPT;
    endfunction

endpackage

// File: rtl/wbr_lat_check.sv
module wbr_lat_check #(
    parameter int DEPTH = 8,
    parameter int LAT_W = 5
) (
    input  logic [LAT_W-1:0] lat,
    output logic             legal,
    output logic [LAT_W-1:0] slot_idx
);
    localparam logic [LAT_W-1:0] MAX_LAT = LAT_W'(DEPTH);
    localparam logic [LAT_W-1:0] ONE     = LAT_W'(1);

    always_comb begin
        legal    = (lat != '0) && (lat <= MAX_LAT);
        slot_idx = legal ? (lat - ONE) : '0;
    end
endmodule

// File: rtl/wbr_slot_line.sv
module wbr_slot_line #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 5,
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LAT_W-1:0] probe_lat,
    output logic             probe_busy,
    input  logic             ins_en,
    input  logic [LAT_W-1:0] ins_idx,
    input  logic [TAG_W-1:0] ins_tag,
    output logic             head_valid,
    output logic [TAG_W-1:0] head_tag
);
    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
    } slot_t;

    slot_t line_q [DEPTH];
    slot_t line_d [DEPTH];
    logic [DEPTH-1:0] hit_vec;

    // Probe: latency L examines the entry that shifts into index L-1 this cycle.
    assign hit_vec[0] = 1'b0;
    for (genvar i = 1; i < DEPTH; i++) begin : g_probe
        assign hit_vec[i] = line_q[i].valid && (probe_lat == LAT_W'(i));
    end
    assign probe_busy = |hit_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        slot_t shifted;
        if (i == DEPTH - 1) begin : g_tail
            assign shifted = '0;
        end else begin : g_body
            assign shifted = line_q[i+1];
        end

        always_comb begin
            if (ins_en && ins_idx == LAT_W'(i))
                line_d[i] = '{valid: 1'b1, tag: ins_tag};
            else
                line_d[i] = shifted;
        end

        always_ff @(posedge clk) begin
            if (rst)
                line_q[i] <= '0;
            else
                line_q[i] <= line_d[i];
        end
    end

    assign head_valid = line_q[0].valid;
    assign head_tag   = line_q[0].tag;

    // R2: an insertion is visible at its index on the following cycle.
    a_r2_booking_lands: assert property (@(posedge clk) disable iff (rst)
        ins_en |=> (line_q[$past(ins_idx)].valid && line_q[$past(ins_idx)].tag == $past(ins_tag)));

    // R7: without an insertion the head takes what sat one position behind it.
    a_r7_head_shifts: assert property (@(posedge clk) disable iff (rst)
        !(ins_en && ins_idx == '0) |=> (line_q[0] == $past(line_q[1 % DEPTH]) || DEPTH == 1));

    // R5: the tail only fills by a booking of the maximum latency.
    a_r5_tail_fill: assert property (@(posedge clk) disable iff (rst)
        !(ins_en && ins_idx == LAT_W'(DEPTH - 1)) |=> !line_q[DEPTH-1].valid);
endmodule

// File: rtl/wb_slot_reserve.sv
module wb_slot_reserve
    import wbr_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAG_W = 5,
    parameter int LAT_W = $clog2(DEPTH + 1) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iss_req,
    input  logic [LAT_W-1:0] iss_lat,
    input  logic [TAG_W-1:0] iss_dst,
    output logic             iss_accept,
    output logic             iss_stall,
    output logic             lat_err,
    output logic             wb_en,
    output logic [TAG_W-1:0] wb_tag
);
    logic             lat_ok;
    logic [LAT_W-1:0] slot_idx;
    logic             slot_busy;
    verdict_e         verdict;

    wbr_lat_check #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_lat (
        .lat      (iss_lat),
        .legal    (lat_ok),
        .slot_idx (slot_idx)
    );

    assign verdict    = decide(iss_req, lat_ok, slot_busy);
    assign iss_accept = (verdict == VERDICT_ACCEPT);
    assign iss_stall  = (verdict == VERDICT_STALL);
    assign lat_err    = (verdict == VERDICT_ILLEGAL);

    wbr_slot_line #(.DEPTH(DEPTH), .TAG_W(TAG_W), .LAT_W(LAT_W)) u_line (
        .clk        (clk),
        .rst        (rst),
        .probe_lat  (iss_lat),
        .probe_busy (slot_busy),
        .ins_en     (iss_accept),
        .ins_idx    (slot_idx),
        .ins_tag    (iss_dst),
        .head_valid (wb_en),
        .head_tag   (wb_tag)
    );

    a_r8_verdict_excl: assert property (@(posedge clk) disable iff (rst)
        !(iss_accept && iss_stall));

    a_r4_illegal_inert: assert property (@(posedge clk) disable iff (rst)
        lat_err |-> (!iss_accept && !iss_stall));

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !iss_req |-> (!iss_accept && !iss_stall && !lat_err));

    a_r5_full_latency_free: assert property (@(posedge clk) disable iff (rst)
        (iss_req && iss_lat == LAT_W'(DEPTH)) |-> iss_accept);
endmodule

// File: tb/wb_slot_reserve_tb.sv
module wb_slot_reserve_tb;
    localparam int DEPTH = 8;
    localparam int TAG_W = 5;
    localparam int LAT_W = $clog2(DEPTH + 1) + 1;

    logic             clk = 1'b0;
    logic             rst;
    logic             iss_req;
    logic [LAT_W-1:0] iss_lat;
    logic [TAG_W-1:0] iss_dst;
    logic             iss_accept, iss_stall, lat_err, wb_en;
    logic [TAG_W-1:0] wb_tag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference bookings, index 0 is due in the current cycle
    bit           mv [DEPTH];
    int           mt [DEPTH];

    always #5 clk = ~clk;

    wb_slot_reserve #(.DEPTH(DEPTH), .TAG_W(TAG_W), .LAT_W(LAT_W)) u_dut (
        .clk(clk), .rst(rst), .iss_req(iss_req), .iss_lat(iss_lat), .iss_dst(iss_dst),
        .iss_accept(iss_accept), .iss_stall(iss_stall), .lat_err(lat_err),
        .wb_en(wb_en), .wb_tag(wb_tag)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) begin
            mv[i] = 0;
            mt[i] = 0;
        end
    endtask

    task automatic step(input bit r, input int lat, input int dst);
        bit legal, busy, e_acc, e_st, e_err;
        string tag;
        @(negedge clk);
        iss_req = r;
        iss_lat = LAT_W'(lat);
        iss_dst = TAG_W'(dst);
        #1;
        legal = (lat >= 1) && (lat <= DEPTH);
        busy  = legal && (lat < DEPTH) && mv[lat];
        e_acc = r && legal && !busy;
        e_st  = r && legal && busy;
        e_err = r && !legal;
        if (!r) tag = "R6";
        else if (!legal) tag = "R4";
        else if (lat == DEPTH) tag = "R5";
        else if (busy) tag = "R3";
        else tag = "R2";
        check(tag, "iss_accept", int'(iss_accept), int'(e_acc));
        check(tag, "iss_stall", int'(iss_stall), int'(e_st));
        check(tag, "lat_err", int'(lat_err), int'(e_err));
        check("R8", "accept_and_stall", int'(iss_accept && iss_stall), 0);
        check("R7", "wb_en", int'(wb_en), int'(mv[0]));
        if (mv[0])
            check("R2", "wb_tag", int'(wb_tag), mt[0]);
        @(posedge clk);
        for (int i = 0; i < DEPTH - 1; i++) begin
            mv[i] = mv[i+1];
            mt[i] = mt[i+1];
        end
        mv[DEPTH-1] = 0;
        mt[DEPTH-1] = 0;
        if (e_acc) begin
            mv[lat-1] = 1;
            mt[lat-1] = dst;
        end
    endtask

    task automatic drain();
        for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1;
        iss_req = 1'b0;
        iss_lat = '0;
        iss_dst = '0;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "wb_en after reset", int'(wb_en), 0);

        // every latency value from an empty line, each drained on its own
        for (int l = 0; l < 16; l++) begin
            step(1, l, l + 3);
            drain();
        end

        // R3: latency 3 booked, then latency 2 one cycle later targets the same cycle
        step(1, 3, 17);
        step(1, 2, 9);
        step(1, 2, 10);
        drain();

        // R5: maximum latency every cycle, all accepted and all written back
        for (int i = 0; i < 3 * DEPTH; i++) step(1, DEPTH, i % 32);
        drain();

        // R4: illegal latencies between legal ones do not book anything
        step(1, 4, 6);
        step(1, 0, 7);
        step(1, DEPTH + 1, 8);
        step(1, 15, 9);
        drain();

        // R1: reset in the middle of pending bookings clears them
        step(1, 5, 11);
        step(1, 7, 12);
        @(negedge clk);
        iss_req = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        model_clear();
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < DEPTH + 1; i++) begin
            #1;
            check("R1", "wb_en after mid-run reset", int'(wb_en), 0);
            @(negedge clk);
        end

        // mixed traffic sweep
        for (int i = 0; i < 3000; i++) begin
            int l;
            l = ($urandom_range(9) == 0) ? int'($urandom_range(15)) : int'($urandom_range(DEPTH, 1));
            step($urandom_range(3) != 0, l, int'($urandom_range(31)));
        end
        drain();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule